// File: doc/BRIEF.md
# Blanked Multiplexed Seven-Segment Scanner

This block drives a four-digit seven-segment display with common anodes. It scans the digits one after another and lights only one digit at a time. Each digit has a fixed time slot. Each slot opens with a blanking phase in which every anode select is inactive. The cathode lines change only inside that phase, so the glyph of one digit never shows faintly on its neighbour.

The block takes four 4-bit decimal digits on one packed bus. It captures all four together at the start of every frame, so a displayed frame never mixes old and new values. It turns each digit into an active-low segment pattern. Codes 10 to 15 show no segments. The decimal point output stays high, so the point stays dark. At the default 100 MHz clock, each slot lasts 250,000 cycles (2.5 ms) with 1,000 blanking cycles. This gives a full refresh of about 100 Hz.

Top module: `segscan_top`

## Requirements
- R1: While the synchronous reset is high, anodes read 4'b1111 and cathodes read 7'h7F. After reset is released, the scan starts at digit 0 and the counting starts from the first slot cycle.
- R2: Digit k is enabled by driving 0 on anode bit k and 1 on the other anode bits. The anode codes are 4'b1110, 4'b1101, 4'b1011 and 4'b0111 for digits 0 to 3. Slots follow the order 0, 1, 2, 3 and then repeat. Each slot lasts SLOT_CYCLES clocks. All outputs are registered, so the outputs lag the internal slot position by one clock.
- R3: For the first BLANK_CYCLES clocks of every slot, all anodes are 4'b1111. For the rest of the slot, the slot's anode code is active.
- R4: Cathodes are active-low, with bit 0 as segment a through bit 6 as segment g. The patterns for digits 0 to 9 are 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00 and 7'h10.
- R5: Digit values from 10 to 15 give the pattern 7'h7F (all segments off).
- R6: The decimal-point output is always 1.
- R7: The cathode outputs change only on clock edges after which all anodes are 4'b1111. The new pattern is loaded on the second cycle of each slot's blanking phase.
- R8: The digit inputs are captured once per frame, on the first cycle of the digit-0 slot. Input changes at any other time take effect only in the next frame.
- R9: At most one anode bit is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 100 MHz by default |
| rst_i | input | 1 | Synchronous reset, active high |
| digits_i | input | 4*NUM_DIGITS | Digit k on bits [4k+3:4k] |
| an_n_o | output | NUM_DIGITS | Anode selects, active low |
| seg_n_o | output | 7 | Cathodes a..g at bits 0..6, active low |
| dp_n_o | output | 1 | Decimal point cathode, held high |

## Verification
The assertions assume that reset is held for at least one clock edge before any checking starts. They also assume the parameters pass the elaboration checks: at least two blanking cycles, and a slot longer than its blanking phase. They place no constraint on the digit inputs.

The stimulus changes digit values at random cycles across the whole 0 to 15 range, including in the middle of a frame. It also applies a reset during a scan. These inputs stay inside what the assertions assume. The bench uses a short slot so that many frames fit in one run.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

   localparam int DIGIT_W = 4;
   localparam int SEG_W   = 7;

   localparam logic [SEG_W-1:0] SEG_DARK = 7'h7F;

   // Active-low glyph: bit 0 = segment a ... bit 6 = segment g
   function automatic logic [SEG_W-1:0] glyph_of(input logic [DIGIT_W-1:0] v);
      logic [SEG_W-1:0] g;
      case (v)
         4'd0:    g = 7'h40;
         4'd1:    g = 7'h79;
         4'd2:    g = 7'h24;
         4'd3:    g = 7'h30;
         4'd4:    g = 7'h19;
         4'd5:    g = 7'h12;
         4'd6:    g = 7'h02;
         4'd7:    g = 7'h78;
         4'd8:    g = 7'h00;
         4'd9:    g = 7'h10;
         default: g = SEG_DARK;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/segscan_timer.sv
module segscan_timer #(
   parameter int SLOT_CYCLES  = 250000,
   parameter int BLANK_CYCLES = 1000
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic slot_first_o,
   output logic slot_last_o,
   output logic blank_o,
   output logic load_o
);
   localparam int CNT_W = $clog2(SLOT_CYCLES);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(SLOT_CYCLES - 1);
   localparam logic [CNT_W-1:0] BLANK = CNT_W'(BLANK_CYCLES);

   if (BLANK_CYCLES < 2) begin : g_chk_blank
      $error("segscan_timer: BLANK_CYCLES must be at least 2");
   end
   if (SLOT_CYCLES <= BLANK_CYCLES) begin : g_chk_slot
      $error("segscan_timer: SLOT_CYCLES must exceed BLANK_CYCLES");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)              cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign slot_first_o = (cnt_q == '0);
   assign slot_last_o  = (cnt_q == LAST);
   assign blank_o      = (cnt_q < BLANK);
   assign load_o       = (cnt_q == CNT_W'(1));

   // R2: slot position never leaves its range
   p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST);

   // R2: wrap follows the last slot cycle
   p_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      slot_last_o |=> slot_first_o);

endmodule

// File: rtl/segscan_index.sv
module segscan_index #(
   parameter int NUM_DIGITS = 4
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic                          slot_first_i,
   input  logic                          slot_last_i,
   output logic [$clog2(NUM_DIGITS)-1:0] idx_o,
   output logic                          frame_start_o
);
   localparam int IDX_W = $clog2(NUM_DIGITS);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_DIGITS - 1);

   if (NUM_DIGITS < 2) begin : g_chk_n
      $error("segscan_index: NUM_DIGITS must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) idx_q <= '0;
      else if (slot_last_i) idx_q <= (idx_q == TOP) ? '0 : idx_q + 1'b1;
   end

   assign idx_o         = idx_q;
   assign frame_start_o = slot_first_i && (idx_q == '0);

   // R2: digit index only moves at the end of a slot
   p_hold_idx_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !slot_last_i |=> $stable(idx_q));

   // R2: index stays within the digit count
   p_idx_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      idx_q <= TOP);

endmodule

// File: rtl/segscan_latch.sv
module segscan_latch
   import segscan_pkg::*;
#(
   parameter int NUM_DIGITS = 4
) (
   input  logic                            clk_i,
   input  logic                            rst_i,
   input  logic                            capture_i,
   input  logic [DIGIT_W*NUM_DIGITS-1:0]   digits_i,
   input  logic [$clog2(NUM_DIGITS)-1:0]   idx_i,
   output logic [DIGIT_W-1:0]              digit_o
);
   logic [DIGIT_W-1:0] held_q [NUM_DIGITS];

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (rst_i)          held_q[k] <= '0;
         else if (capture_i) held_q[k] <= digits_i[k*DIGIT_W +: DIGIT_W];
      end
   end

   assign digit_o = held_q[idx_i];

   // R8: captured frame stays fixed between frame starts
   p_frame_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !capture_i |=> $stable(digit_o) || !$stable(idx_i));

endmodule

// File: rtl/segscan_top.sv
module segscan_top
   import segscan_pkg::*;
#(
   parameter int NUM_DIGITS   = 4,
   parameter int SLOT_CYCLES  = 250000,
   parameter int BLANK_CYCLES = 1000
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic [DIGIT_W*NUM_DIGITS-1:0] digits_i,
   output logic [NUM_DIGITS-1:0]         an_n_o,
   output logic [SEG_W-1:0]              seg_n_o,
   output logic                          dp_n_o
);
   localparam int IDX_W = $clog2(NUM_DIGITS);
   localparam logic [NUM_DIGITS-1:0] AN_OFF = '1;

   logic             slot_first, slot_last, blank, load, frame_start;
   logic [IDX_W-1:0] idx;
   logic [DIGIT_W-1:0] cur_digit;

   segscan_timer #(
      .SLOT_CYCLES (SLOT_CYCLES),
      .BLANK_CYCLES(BLANK_CYCLES)
   ) u_timer (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .slot_first_o(slot_first),
      .slot_last_o (slot_last),
      .blank_o     (blank),
      .load_o      (load)
   );

   segscan_index #(
      .NUM_DIGITS(NUM_DIGITS)
   ) u_index (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .slot_first_i (slot_first),
      .slot_last_i  (slot_last),
      .idx_o        (idx),
      .frame_start_o(frame_start)
   );

   segscan_latch #(
      .NUM_DIGITS(NUM_DIGITS)
   ) u_latch (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .capture_i(frame_start),
      .digits_i (digits_i),
      .idx_i    (idx),
      .digit_o  (cur_digit)
   );

   logic [NUM_DIGITS-1:0] an_q;
   logic [SEG_W-1:0]      seg_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         an_q  <= AN_OFF;
         seg_q <= SEG_DARK;
      end else begin
         an_q <= blank ? AN_OFF : ~(NUM_DIGITS'(1) << idx);
         if (load) seg_q <= glyph_of(cur_digit);
      end
   end

   assign an_n_o  = an_q;
   assign seg_n_o = seg_q;
   assign dp_n_o  = 1'b1;

   // R7: cathodes never move while a digit is lit
   p_cath_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(seg_q) |-> an_q == AN_OFF);

   // R9: never more than one anode enabled
   p_one_anode_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(~an_q));

   // R3: a slot always opens dark
   p_blank_open_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      slot_first |=> an_q == AN_OFF);

   // R6: decimal point stays dark
   p_dp_dark_r6: assert property (@(posedge clk_i) dp_n_o == 1'b1);

endmodule

// File: tb/segscan_top_test.sv
module segscan_top_test;
   localparam int N     = 4;
   localparam int SLOT  = 40;
   localparam int BLANK = 6;
   localparam int FRAME = N * SLOT;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [4*N-1:0] digits = '0;
   logic [N-1:0]  an_n;
   logic [6:0]    seg_n;
   logic          dp_n;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   int n     = 0;              // edges since reset release
   logic [4*N-1:0] cap [128];  // digits captured per frame
   logic [6:0] prev_seg = 7'h7F;

   always #2.5 clk = ~clk;

   segscan_top #(.NUM_DIGITS(N), .SLOT_CYCLES(SLOT), .BLANK_CYCLES(BLANK)) uut (
      .clk_i(clk), .rst_i(rst), .digits_i(digits),
      .an_n_o(an_n), .seg_n_o(seg_n), .dp_n_o(dp_n));

   function automatic logic [6:0] ref_glyph(input int v);
      case (v)
         0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
         4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
         8: return 7'h00;  9: return 7'h10;
         default: return 7'h7F;
      endcase
   endfunction

   // R8 model: inputs captured on the first cycle of each frame
   always @(posedge clk) begin
      if (rst) n <= 0;
      else begin
         if (n % FRAME == 0) cap[(n / FRAME) % 128] <= digits;
         n <= n + 1;
      end
   end

   task automatic check_now();
      logic [N-1:0] ean;
      logic [6:0]   eseg;
      int p, c, i, q, v;
      if (rst || n == 0) begin
         ean = '1; eseg = 7'h7F;
         total++; if (an_n !== ean || seg_n !== eseg) begin
            bad++; $display("FAIL R1 reset an=%b seg=%h exp an=%b seg=%h", an_n, seg_n, ean, eseg);
         end
      end else begin
         p = n - 1; c = p % SLOT; i = (p / SLOT) % N;
         ean = (c < BLANK) ? '1 : ~(N'(1) << i);
         total++; if (an_n !== ean) begin
            bad++;
            if (c < BLANK) $display("FAIL R3 an=%b exp=%b pos=%0d", an_n, ean, p);
            else           $display("FAIL R2 an=%b exp=%b pos=%0d", an_n, ean, p);
         end
         if (p == 0) begin eseg = 7'h7F; v = 15; end
         else begin
            q = (c >= 1) ? p - (c - 1) : p - SLOT + 1;
            v = int'(cap[(q / FRAME) % 128][((q / SLOT) % N) * 4 +: 4]);
            eseg = ref_glyph(v);
         end
         total++; if (seg_n !== eseg) begin
            bad++;
            if (v > 9) $display("FAIL R5 seg=%h exp=%h pos=%0d", seg_n, eseg, p);
            else       $display("FAIL R4 seg=%h exp=%h pos=%0d (R8 frame value %0d)", seg_n, eseg, p, v);
         end
      end
      total++; if (dp_n !== 1'b1) begin
         bad++; $display("FAIL R6 dp=%b exp=1", dp_n);
      end
      total++; if ($countones(~an_n) > 1) begin
         bad++; $display("FAIL R9 an=%b exp=at most one low", an_n);
      end
      if (seg_n !== prev_seg) begin
         total++; if (an_n !== '1) begin
            bad++; $display("FAIL R7 seg %h->%h with an=%b exp an=1111", prev_seg, seg_n, an_n);
         end
      end
      prev_seg = seg_n;
   endtask

   task automatic run(input int cycles, input int chg_pct);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         check_now();
         if ($urandom_range(99) < chg_pct) digits = 16'($urandom);
      end
   endtask

   initial begin
      void'($urandom(32'h5E65CA1));
      repeat (3) @(negedge clk);
      check_now();                      // R1 reset state
      @(negedge clk); rst = 1'b0;
      digits = 16'h3210;
      run(FRAME, 0);                    // R4 digits 0..3
      digits = 16'h7654; run(FRAME, 0); // R4 4..7
      digits = 16'hBA98; run(FRAME, 0); // R4 8,9 and R5 10,11
      digits = 16'hFEDC; run(FRAME, 0); // R5 12..15
      run(FRAME * 20, 5);               // random, mid-frame changes (R8)
      digits = 16'h1111; run(FRAME + 2, 0);
      digits = 16'h9999; run(SLOT * 2, 0); // R8 change mid-frame: old frame held
      rst = 1'b1; run(4, 0);            // R1 mid-scan reset
      rst = 1'b0; run(FRAME * 10, 10);  // R1 restart at digit 0
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule